// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches 19 asynchronous input lines and turns chosen signal transitions into latched pending flags. Each line is first brought into the local clock domain by a two-stage synchronizer. A transition is then detected by comparing consecutive synchronized samples. Software picks, per line, whether rising transitions, falling transitions or both are of interest. It can also force a line pending directly. A pending flag stays set until software writes a 1 to it.

Pending flags are gated by a per-line request enable and drive seven request outputs. Lines 0 through 4 each have a dedicated output. Lines 5 through 9 share one output, and lines 10 through 15 share another. Lines 16 through 18 latch like the rest but appear on a separate 3-bit request vector. A second per-line enable turns selected transitions into one-cycle event pulses, which leave the pending flags alone.

Control uses a word-addressed register bus with separate write and read strobes and 32-bit data.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq_out`, `irq_hi` and `evt_out` are all 0.
- R2: When a line's rising-select bit is 1 and its input rises, the line's pending bit becomes 1 on the third clock edge that samples the new level. It is still 0 after the second such edge.
- R3: When a line's falling-select bit is 1 and its input falls, the line's pending bit is set with the same latency as in R2. With both select bits at 1, either transition sets it.
- R4: A transition whose polarity is not selected on that line leaves the line's pending bit unchanged.
- R5: Writing the pending register (word 5) clears every bit written as 1 on that clock edge and leaves bits written as 0 unchanged.
- R6: If a selected transition and a clearing write of 1 hit the same pending bit on the same clock edge, the bit stays 1.
- R7: Writing 1 to a bit of the software-set register (word 4) sets that bit and the matching pending bit on the clock edge of the write. The software-set bit returns to 0 when that pending bit is cleared.
- R8: `irq_out[i]` for i = 0 to 4 equals pending[i] AND enable[i]. `irq_out[5]` is the OR of the enabled pending bits of lines 5 to 9, and `irq_out[6]` is the OR for lines 10 to 15. The request enable is word 0. A pending bit whose enable is 0 drives no request, but it is retained and raises the request once the enable is set.
- R9: `irq_hi[k]` equals pending[16+k] AND enable[16+k]. Lines 16 to 18 never drive `irq_out`.
- R10: When a selected transition occurs on a line whose event-enable bit (word 1) is 1, `evt_out` for that line is 1 for exactly one cycle. This happens on the same clock edge that sets the pending bit. The event enable has no effect on pending bits.
- R11: The registers sit at word addresses 0 to 5: request enable, event enable, rising select, falling select, software set, pending. Rising select is word 2 and falling select is word 3. A read presents data on `bus_rdata` after the clock edge that samples `bus_rd`. Bits 31 to 19 read 0 and ignore writes, and words 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 19 | Asynchronous external lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 7 | Grouped request outputs for lines 0 to 15 |
| irq_hi | output | 3 | Requests for lines 16 to 18 |
| evt_out | output | 19 | One-cycle event pulses per line |

## Verification
An input transition sets the pending flag and the event pulse three clock edges after it is driven: two synchronizer stages and the edge register. The bench drives inputs at a falling clock edge and checks that the output is still low after two rising edges and high after the third. A bus write takes effect on the rising edge that samples it, so the bench reads back status only after that edge. Read data is valid one edge after the read strobe, and request outputs follow the pending flags without further delay. The collision case places the clearing write on exactly the edge where the transition lands.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam int NLINES   = 19;
    localparam int DW       = 32;
    localparam int AW       = 3;
    localparam int N_SINGLE = 5;
    localparam int GA_LO    = 5;
    localparam int GA_HI    = 9;
    localparam int GB_LO    = 10;
    localparam int GB_HI    = 15;
    localparam int NIRQ     = N_SINGLE + 2;
    localparam int NHI      = NLINES - GB_HI - 1;

    typedef enum logic [AW-1:0] {
        REG_IRQ_EN   = 3'd0,
        REG_EVT_EN   = 3'd1,
        REG_RISE_SEL = 3'd2,
        REG_FALL_SEL = 3'd3,
        REG_SW_SET   = 3'd4,
        REG_PEND     = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [NLINES-1:0] irq_en;
        logic [NLINES-1:0] evt_en;
        logic [NLINES-1:0] rise_sel;
        logic [NLINES-1:0] fall_sel;
        logic [NLINES-1:0] sw_set;
        logic [NLINES-1:0] pend;
        logic [NLINES-1:0] evt;
        logic [DW-1:0]     rdata;
    } regs_t;
endpackage

// File: rtl/eirq_edge_detect.sv
module eirq_edge_detect #(
    parameter int N = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = din;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        assign rise[i] = sync_q.s2[i] & ~sync_q.prev[i];
        assign fall[i] = ~sync_q.s2[i] & sync_q.prev[i];
    end

    // R2: a detected rise implies the raw input was high two edges earlier
    assert_rise_from_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |-> ((rise & ~$past(din, 2)) == '0));

    // R3: the same line cannot report two falls in a row
    assert_no_double_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall != '0) |=> ((fall & $past(fall)) == '0));
endmodule

// File: rtl/eirq_regfile.sv
module eirq_regfile
    import eirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [NLINES-1:0] rise,
    input  logic [NLINES-1:0] fall,
    output logic [NLINES-1:0] irq_en,
    output logic [NLINES-1:0] pend,
    output logic [NLINES-1:0] evt,
    output logic [DW-1:0]     rdata
);
    regs_t             regs_d, regs_q;
    logic [NLINES-1:0] wmask;
    logic [NLINES-1:0] edge_hit;
    logic [NLINES-1:0] sw_hit;
    logic [NLINES-1:0] clr;

    always_comb begin
        regs_d   = regs_q;
        wmask    = bus_wdata[NLINES-1:0];
        edge_hit = (rise & regs_q.rise_sel) | (fall & regs_q.fall_sel);
        sw_hit   = '0;
        clr      = '0;
        if (bus_wr) begin
            case (bus_addr)
                REG_IRQ_EN:   regs_d.irq_en   = wmask;
                REG_EVT_EN:   regs_d.evt_en   = wmask;
                REG_RISE_SEL: regs_d.rise_sel = wmask;
                REG_FALL_SEL: regs_d.fall_sel = wmask;
                REG_SW_SET:   sw_hit          = wmask;
                REG_PEND:     clr             = wmask;
                default:      ;
            endcase
        end
        regs_d.pend   = (regs_q.pend & ~clr) | edge_hit | sw_hit;
        regs_d.sw_set = (regs_q.sw_set | sw_hit) & regs_d.pend;
        regs_d.evt    = edge_hit & regs_q.evt_en;
        if (bus_rd) begin
            case (bus_addr)
                REG_IRQ_EN:   regs_d.rdata = DW'(regs_q.irq_en);
                REG_EVT_EN:   regs_d.rdata = DW'(regs_q.evt_en);
                REG_RISE_SEL: regs_d.rdata = DW'(regs_q.rise_sel);
                REG_FALL_SEL: regs_d.rdata = DW'(regs_q.fall_sel);
                REG_SW_SET:   regs_d.rdata = DW'(regs_q.sw_set);
                REG_PEND:     regs_d.rdata = DW'(regs_q.pend);
                default:      regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign irq_en = regs_q.irq_en;
    assign pend   = regs_q.pend;
    assign evt    = regs_q.evt;
    assign rdata  = regs_q.rdata;

    // R2: every selected edge leaves its pending bit set
    assert_edge_sets_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((pend & $past(edge_hit)) == $past(edge_hit)));

    // R5: a clearing write empties the written bits unless an edge landed
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_PEND)
        |=> ((pend & $past(bus_wdata[NLINES-1:0] & ~edge_hit)) == '0));

    // R7: a software set shows up in pending on the write edge
    assert_sw_sets_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_SW_SET)
        |=> ((pend & $past(bus_wdata[NLINES-1:0])) == $past(bus_wdata[NLINES-1:0])));

    // R10: event pulses last a single cycle
    assert_evt_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((evt & $past(evt)) == '0));
endmodule

// File: rtl/eirq_req_map.sv
module eirq_req_map
    import eirq_pkg::*;
(
    input  logic [NLINES-1:0] pend,
    input  logic [NLINES-1:0] irq_en,
    output logic [NIRQ-1:0]   irq_out,
    output logic [NHI-1:0]    irq_hi
);
    logic [NLINES-1:0] active;

    assign active = pend & irq_en;

    for (genvar i = 0; i < N_SINGLE; i++) begin : g_single
        assign irq_out[i] = active[i];
    end

    assign irq_out[N_SINGLE]     = |active[GA_HI:GA_LO];
    assign irq_out[N_SINGLE + 1] = |active[GB_HI:GB_LO];
    assign irq_hi                = active[NLINES-1:GB_HI+1];
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] ext_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NIRQ-1:0]   irq_out,
    output logic [NHI-1:0]    irq_hi,
    output logic [NLINES-1:0] evt_out
);
    logic [NLINES-1:0] rise, fall, irq_en, pend;

    eirq_edge_detect #(.N(NLINES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_in),
        .rise (rise),
        .fall (fall)
    );

    eirq_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .rise     (rise),
        .fall     (fall),
        .irq_en   (irq_en),
        .pend     (pend),
        .evt      (evt_out),
        .rdata    (bus_rdata)
    );

    eirq_req_map u_map (
        .pend   (pend),
        .irq_en (irq_en),
        .irq_out(irq_out),
        .irq_hi (irq_hi)
    );

    // R8: any request output needs an enabled pending line behind it
    assert_req_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out != '0) || (irq_hi != '0)) |-> ((pend & irq_en) != '0));
endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] ext_in = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [6:0]  irq_out;
    logic [2:0]  irq_hi;
    logic [18:0] evt_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [2:0] A_EN = 3'd0, A_EVT = 3'd1, A_RISE = 3'd2,
                           A_FALL = 3'd3, A_SW = 3'd4, A_PEND = 3'd5;

    always #4 clk = ~clk;

    ext_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in),
        .bus_wr(wr), .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq_out(irq_out), .irq_hi(irq_hi), .evt_out(evt_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        chk(req, rdata, exp);
    endtask

    task automatic cleanup();
        bus_write(A_RISE, 0);
        bus_write(A_FALL, 0);
        bus_write(A_EVT, 0);
        wait_n(4);
        bus_write(A_PEND, 32'h7FFFF);
        bus_write(A_EN, 0);
    endtask

    task automatic t_reset();
        chk("R1 irq_out", 32'(irq_out), 0);
        chk("R1 irq_hi", 32'(irq_hi), 0);
        chk("R1 evt_out", 32'(evt_out), 0);
        for (int a = 0; a < 6; a++) rd_chk("R1 reg", 3'(a), 0);
    endtask

    task automatic t_regmap();
        bus_write(A_EN, 32'hFFFF_FFFF);
        bus_write(A_EVT, 32'h1234_5678);
        bus_write(A_RISE, 32'hA5A5_A5A5);
        bus_write(A_FALL, 32'h0F0F_0F0F);
        rd_chk("R11 word0", A_EN, 32'h0007_FFFF);
        rd_chk("R11 word1", A_EVT, 32'h0004_5678);
        rd_chk("R11 word2", A_RISE, 32'h0005_A5A5);
        rd_chk("R11 word3", A_FALL, 32'h0007_0F0F);
        rd_chk("R11 word6", 3'd6, 0);
        rd_chk("R11 word7", 3'd7, 0);
        bus_write(A_EN, 0); bus_write(A_EVT, 0);
        bus_write(A_RISE, 0); bus_write(A_FALL, 0);
        rd_chk("R11 pend untouched", A_PEND, 0);
    endtask

    task automatic t_rise();
        bus_write(A_EN, 32'h1);
        bus_write(A_RISE, 32'h1);
        @(negedge clk); ext_in[0] = 1'b1;
        wait_n(2);
        chk("R2 not yet after 2 edges", 32'(irq_out), 0);
        wait_n(1);
        chk("R2 set after 3 edges", 32'(irq_out), 32'h1);
        rd_chk("R2 pend", A_PEND, 32'h1);
        bus_write(A_PEND, 32'h1);
        chk("R5 cleared", 32'(irq_out), 0);
        @(negedge clk); ext_in[0] = 1'b0;
        wait_n(5);
        rd_chk("R4 unselected fall", A_PEND, 0);
        cleanup();
    endtask

    task automatic t_fall();
        bus_write(A_FALL, 32'h8);
        @(negedge clk); ext_in[3] = 1'b1;
        wait_n(5);
        rd_chk("R4 unselected rise", A_PEND, 0);
        @(negedge clk); ext_in[3] = 1'b0;
        wait_n(2);
        rd_chk("R3 fall pend", A_PEND, 32'h8);
        bus_write(A_PEND, 32'h8);
        bus_write(A_RISE, 32'h80);
        bus_write(A_FALL, 32'h80);
        @(negedge clk); ext_in[7] = 1'b1;
        wait_n(3);
        rd_chk("R3 both rise", A_PEND, 32'h80);
        bus_write(A_PEND, 32'h80);
        @(negedge clk); ext_in[7] = 1'b0;
        wait_n(3);
        rd_chk("R3 both fall", A_PEND, 32'h80);
        cleanup();
    endtask

    task automatic t_clear();
        bus_write(A_SW, 32'h6);
        bus_write(A_PEND, 32'h0);
        rd_chk("R5 write0 keeps", A_PEND, 32'h6);
        bus_write(A_PEND, 32'h2);
        rd_chk("R5 partial", A_PEND, 32'h4);
        bus_write(A_PEND, 32'hFFFF_FFFF);
        rd_chk("R5 all", A_PEND, 0);
    endtask

    task automatic t_collide();
        bus_write(A_RISE, 32'h4);
        bus_write(A_FALL, 32'h4);
        @(negedge clk); ext_in[2] = 1'b1;
        wait_n(4);
        rd_chk("R6 setup", A_PEND, 32'h4);
        @(negedge clk); ext_in[2] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr = 1'b1; addr = A_PEND; wdata = 32'h4;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
        rd_chk("R6 edge wins", A_PEND, 32'h4);
        bus_write(A_PEND, 32'h4);
        rd_chk("R6 later clear", A_PEND, 0);
        cleanup();
    endtask

    task automatic t_sw();
        bus_write(A_EN, 32'h10);
        bus_write(A_SW, 32'h10);
        chk("R7 irq at write edge", 32'(irq_out), 32'h10);
        rd_chk("R7 sw bit", A_SW, 32'h10);
        bus_write(A_PEND, 32'h10);
        rd_chk("R7 sw auto clear", A_SW, 0);
        cleanup();
    endtask

    task automatic t_groups();
        bus_write(A_EN, 32'h7FFFF);
        bus_write(A_SW, 32'h40);
        chk("R8 group 5-9", 32'(irq_out), 32'h20);
        bus_write(A_PEND, 32'h40);
        bus_write(A_SW, 32'h1000);
        chk("R8 group 10-15", 32'(irq_out), 32'h40);
        bus_write(A_PEND, 32'h1000);
        bus_write(A_SW, 32'h4);
        chk("R8 single 2", 32'(irq_out), 32'h4);
        bus_write(A_PEND, 32'h4);
        bus_write(A_EN, 32'h7FFBF);
        bus_write(A_SW, 32'h40);
        chk("R8 masked", 32'(irq_out), 0);
        bus_write(A_EN, 32'h7FFFF);
        chk("R8 retained", 32'(irq_out), 32'h20);
        bus_write(A_PEND, 32'h40);
        bus_write(A_SW, 32'h20000);
        chk("R9 irq_hi", 32'(irq_hi), 32'h2);
        chk("R9 no group", 32'(irq_out), 0);
        cleanup();
    endtask

    task automatic t_event();
        bus_write(A_EVT, 32'h800);
        @(negedge clk); ext_in[11] = 1'b1;
        wait_n(3);
        chk("R10 unselected no evt", 32'(evt_out), 0);
        rd_chk("R10 evt_en no pend", A_PEND, 0);
        bus_write(A_EVT, 32'h200);
        bus_write(A_RISE, 32'h200);
        @(negedge clk); ext_in[9] = 1'b1;
        wait_n(2);
        chk("R10 evt not yet", 32'(evt_out), 0);
        wait_n(1);
        chk("R10 evt pulse", 32'(evt_out), 32'h200);
        wait_n(1);
        chk("R10 evt one cycle", 32'(evt_out), 0);
        rd_chk("R10 pend from select", A_PEND, 32'h200);
        cleanup();
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_regmap();
        t_rise();
        t_fall();
        t_clear();
        t_collide();
        t_sw();
        t_groups();
        t_event();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule